// File: doc/BRIEF.md
# BCD Time-of-Day Register File

This block keeps calendar time in packed BCD, from hundredths of a second up to a two-digit year, on a 24-hour clock. A set of live counters advances once for every pulse on a 100 Hz tick input. Software never reads those counters directly. It reads a user-visible copy of the time, and that copy is refreshed as a whole once per second, on the tick that carries the hundredths into the seconds.

Access is through a 16-byte register window on a simple synchronous bus: a 4-bit address, a write strobe and write data. Read data follows the address combinationally. A control byte holds two freeze bits. The read-freeze bit holds the visible copy still so that software can take a consistent snapshot. The write-freeze bit also holds the copy still, and lets software enter a new time. When software clears the write-freeze bit, the entered values are loaded into the live counters. A stop bit in the seconds byte halts counting.

Top module: `rtc_bcd_regfile`

## Requirements
- R1: Byte offsets decode as follows: 1 hundredths (tenths digit in bits 7:4), 9 seconds (bits 6:0), 10 minutes (bits 6:0), 11 hours (bits 5:0), 12 weekday (bits 2:0), 13 date (bits 5:0), 14 month (bits 4:0), 15 year, and 8 control. Offsets 0 and 2 to 7 are plain storage. Every field holds two BCD digits, with the tens digit in the upper nibble.
- R2: Each tick pulse advances the live time by one hundredth. The count wraps from 99 to 00, from 59 to 00 for seconds and minutes, from 23 to 00 for hours, from 07 to 01 for the weekday, from 12 to 01 for the month, and from 99 to 00 for the year. Each wrap carries into the next field.
- R3: The visible time bytes are all rewritten together, and only on the tick that carries the hundredths into the seconds. They take the freshly advanced values, so hundredths reads 00 after a refresh. Between refreshes the visible bytes do not change.
- R4: While bit 7 of the seconds byte is 1, ticks are ignored and the live time does not advance. Writing that bit as 0 starts counting.
- R5: While control bit 6 (read freeze) is 1, refreshes are suppressed, but the live counters keep running. After the bit is cleared, the next carry into the seconds shows the live time.
- R6: If control bit 6 is written to 1 in the same cycle as a refresh, that refresh still lands, and freezing starts afterwards.
- R7: While control bit 7 (write freeze) is 1, refreshes are suppressed. A control write that turns bit 7 from 1 to 0 copies the visible time fields into the live counters, and a tick in that same cycle is discarded.
- R8: The date wraps after day 29 of month 02 when the year is divisible by 4 (year 00 included), and after day 28 of month 02 otherwise. It wraps after day 30 in months 04, 06, 09 and 11, and after day 31 in the other months.
- R9: Storage bytes and the unused bits of the time bytes return whatever was last written. A refresh leaves unused bits untouched.
- R10: After reset, seconds reads 0x80 (stopped), the weekday, date and month bytes read 0x01, and every other byte reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse at 100 Hz |
| wr_en | input | 1 | Write strobe |
| addr | input | 4 | Register byte offset |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the addressed byte |

## Verification
The hardest case to reach is a control write that sets the read-freeze bit in exactly the cycle of the second-boundary tick. Any stimulus that drives the two on different cycles never tests whether that refresh lands. The bench counts the hundredths in its own model and drives the tick and the control write together on the 100th pulse. It also runs at random freeze toggles and loads at random valid times. Directed loads just before month ends and year ends, in both leap and common years, drive the date logic across its carries.

// File: rtl/rtc_bcd_pkg.sv
package rtc_bcd_pkg;

    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;
    localparam int NREGS  = 1 << ADDR_W;

    localparam logic [ADDR_W-1:0] OFS_HUND  = 4'd1;
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 4'd8;
    localparam logic [ADDR_W-1:0] OFS_SEC   = 4'd9;
    localparam logic [ADDR_W-1:0] OFS_MIN   = 4'd10;
    localparam logic [ADDR_W-1:0] OFS_HOUR  = 4'd11;
    localparam logic [ADDR_W-1:0] OFS_WDAY  = 4'd12;
    localparam logic [ADDR_W-1:0] OFS_DATE  = 4'd13;
    localparam logic [ADDR_W-1:0] OFS_MONTH = 4'd14;
    localparam logic [ADDR_W-1:0] OFS_YEAR  = 4'd15;

    localparam int BIT_RFRZ = 6;
    localparam int BIT_WFRZ = 7;
    localparam int BIT_STOP = 7;

    typedef struct packed {
        logic [7:0] year;
        logic [4:0] month;
        logic [5:0] date;
        logic [2:0] wday;
        logic [5:0] hour;
        logic [6:0] min;
        logic [6:0] sec;
        logic [7:0] hund;
    } rtc_time_t;

    localparam rtc_time_t TIME_RESET = '{year: 8'h00, month: 5'h01, date: 6'h01,
                                         wday: 3'h1, hour: 6'h00, min: 7'h00,
                                         sec: 7'h00, hund: 8'h00};

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic leap_year(input logic [7:0] y);
        if (y[4] == 1'b0) return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
        return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    endfunction

    function automatic logic [5:0] month_last(input logic [4:0] m, input logic [7:0] y);
        case (m)
            5'h02:                      return leap_year(y) ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
            default:                    return 6'h31;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] field_mask(input int idx);
        case (idx)
            1, 15:  return 8'hFF;
            9, 10:  return 8'h7F;
            11, 13: return 8'h3F;
            12:     return 8'h07;
            14:     return 8'h1F;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] field_of(input rtc_time_t t, input int idx);
        case (idx)
            1:  return t.hund;
            9:  return {1'b0, t.sec};
            10: return {1'b0, t.min};
            11: return {2'b0, t.hour};
            12: return {5'b0, t.wday};
            13: return {2'b0, t.date};
            14: return {3'b0, t.month};
            15: return t.year;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] reset_byte(input int idx);
        case (idx)
            9:          return 8'h80;
            12, 13, 14: return 8'h01;
            default:    return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/rtc_live_counter.sv
module rtc_live_counter
    import rtc_bcd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      run,
    input  logic      load,
    input  rtc_time_t load_val,
    output rtc_time_t cur,
    output rtc_time_t nxt,
    output logic      sec_carry
);
    rtc_time_t q;
    logic step;

    assign step      = tick && run && !load;
    assign sec_carry = step && (q.hund == 8'h99);

    always_comb begin
        logic c_sec, c_min, c_hour, c_date, c_mon;
        nxt   = q;
        c_sec = 1'b0; c_min = 1'b0; c_hour = 1'b0; c_date = 1'b0; c_mon = 1'b0;
        if (step) begin
            c_sec    = (q.hund == 8'h99);
            nxt.hund = c_sec ? 8'h00 : bcd_inc(q.hund);
        end
        if (c_sec) begin
            c_min   = (q.sec == 7'h59);
            nxt.sec = c_min ? 7'h00 : bcd_inc({1'b0, q.sec})[6:0];
        end
        if (c_min) begin
            c_hour  = (q.min == 7'h59);
            nxt.min = c_hour ? 7'h00 : bcd_inc({1'b0, q.min})[6:0];
        end
        if (c_hour) begin
            c_date   = (q.hour == 6'h23);
            nxt.hour = c_date ? 6'h00 : bcd_inc({2'b0, q.hour})[5:0];
        end
        if (c_date) begin
            nxt.wday = (q.wday >= 3'h7) ? 3'h1 : q.wday + 3'h1;
            c_mon    = (q.date == month_last(q.month, q.year));
            nxt.date = c_mon ? 6'h01 : bcd_inc({2'b0, q.date})[5:0];
        end
        if (c_mon) begin
            nxt.month = (q.month == 5'h12) ? 5'h01 : bcd_inc({3'b0, q.month})[4:0];
            if (q.month == 5'h12)
                nxt.year = (q.year == 8'h99) ? 8'h00 : bcd_inc(q.year);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)       q <= TIME_RESET;
        else if (load) q <= load_val;
        else           q <= nxt;
    end

    assign cur = q;
endmodule

// File: rtl/rtc_shadow_regs.sv
module rtc_shadow_regs
    import rtc_bcd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              sec_carry,
    input  rtc_time_t         live_nxt,
    output logic [DATA_W-1:0] rd_data,
    output logic              refresh,
    output logic              load,
    output rtc_time_t         load_val,
    output logic              run,
    output logic [DATA_W-1:0] ctrl
);
    logic [DATA_W-1:0] rv [NREGS];

    assign ctrl    = rv[OFS_CTRL];
    assign refresh = sec_carry && !ctrl[BIT_RFRZ] && !ctrl[BIT_WFRZ];
    assign load    = wr_en && (addr == OFS_CTRL) && ctrl[BIT_WFRZ] && !wr_data[BIT_WFRZ];
    assign run     = !rv[OFS_SEC][BIT_STOP];

    for (genvar i = 0; i < NREGS; i++) begin : g_byte
        localparam logic [DATA_W-1:0] MASK = field_mask(i);
        localparam logic [DATA_W-1:0] RSTV = reset_byte(i);
        logic [DATA_W-1:0] b;
        always_ff @(posedge clk) begin
            if (rst) begin
                b <= RSTV;
            end else if (wr_en && addr == ADDR_W'(i)) begin
                b <= wr_data;
            end else if (refresh && MASK != '0) begin
                b <= (b & ~MASK) | (field_of(live_nxt, i) & MASK);
            end
        end
        assign rv[i] = b;
    end

    always_comb begin
        load_val.hund  = rv[OFS_HUND];
        load_val.sec   = rv[OFS_SEC][6:0];
        load_val.min   = rv[OFS_MIN][6:0];
        load_val.hour  = rv[OFS_HOUR][5:0];
        load_val.wday  = rv[OFS_WDAY][2:0];
        load_val.date  = rv[OFS_DATE][5:0];
        load_val.month = rv[OFS_MONTH][4:0];
        load_val.year  = rv[OFS_YEAR];
    end

    assign rd_data = rv[addr];
endmodule

// File: rtl/rtc_bcd_regfile.sv
module rtc_bcd_regfile
    import rtc_bcd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);
    rtc_time_t         live_q;
    rtc_time_t         live_nxt;
    rtc_time_t         load_val;
    logic              sec_carry;
    logic              refresh;
    logic              load;
    logic              run;
    logic [DATA_W-1:0] ctrl;

    rtc_live_counter u_live (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .run       (run),
        .load      (load),
        .load_val  (load_val),
        .cur       (live_q),
        .nxt       (live_nxt),
        .sec_carry (sec_carry)
    );

    rtc_shadow_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .addr      (addr),
        .wr_data   (wr_data),
        .sec_carry (sec_carry),
        .live_nxt  (live_nxt),
        .rd_data   (rd_data),
        .refresh   (refresh),
        .load      (load),
        .load_val  (load_val),
        .run       (run),
        .ctrl      (ctrl)
    );
endmodule

// File: rtl/rtc_bcd_regfile_checker.sv
module rtc_bcd_regfile_checker
    import rtc_bcd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic              wr_en,
    input logic [DATA_W-1:0] ctrl,
    input logic              run,
    input logic              load,
    input logic              refresh,
    input rtc_time_t         live_q,
    input rtc_time_t         load_val
);
    // R4: a stopped clock keeps its live time
    a_r4_stop_holds_live: assert property (@(posedge clk) disable iff (rst)
        (!run && !load) |=> $stable(live_q));

    // R5 / R7: while frozen and not written, the visible time stays put
    a_r5_freeze_holds_visible: assert property (@(posedge clk) disable iff (rst)
        ((ctrl[BIT_RFRZ] || ctrl[BIT_WFRZ]) && !wr_en) |=> $stable(load_val));

    // R3: a refresh occurs only on the tick that wraps the hundredths
    a_r3_refresh_on_carry: assert property (@(posedge clk) disable iff (rst)
        refresh |-> (tick && run && live_q.hund == 8'h99));

    // R2: the hundredths wrap moves the seconds
    a_r2_carry_moves_seconds: assert property (@(posedge clk) disable iff (rst)
        (tick && run && !load && live_q.hund == 8'h99) |=> (live_q.hund == 8'h00 && live_q.sec != $past(live_q.sec)));

    // R7: a load puts the entered minutes into the live counters
    a_r7_load_copies: assert property (@(posedge clk) disable iff (rst)
        load |=> (live_q.min == $past(load_val.min) && live_q.date == $past(load_val.date)));
endmodule

bind rtc_bcd_regfile rtc_bcd_regfile_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .wr_en    (wr_en),
    .ctrl     (ctrl),
    .run      (run),
    .load     (load),
    .refresh  (refresh),
    .live_q   (live_q),
    .load_val (load_val)
);

// File: tb/rtc_bcd_regfile_bench.sv
module rtc_bcd_regfile_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] addr = 4'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [7:0] vis [16];
    int lh, ls, lm, lhr, lwd, ldt, lmo, ly;

    always #5 clk = ~clk;

    rtc_bcd_regfile u_rtc_bcd_regfile (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data)
    );

    function automatic logic [7:0] to_bcd(input int n);
        return 8'(((n / 10) << 4) | (n % 10));
    endfunction

    function automatic int from_bcd(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic int days_in(input int mo, input int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic logic [7:0] mask_of(input int i);
        case (i)
            1, 15: return 8'hFF;
            9, 10: return 8'h7F;
            11, 13: return 8'h3F;
            12: return 8'h07;
            14: return 8'h1F;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] live_byte(input int i);
        case (i)
            1: return to_bcd(lh);
            9: return to_bcd(ls);
            10: return to_bcd(lm);
            11: return to_bcd(lhr);
            12: return to_bcd(lwd);
            13: return to_bcd(ldt);
            14: return to_bcd(lmo);
            15: return to_bcd(ly);
            default: return 8'h00;
        endcase
    endfunction

    function automatic bit model_adv();
        lh++;
        if (lh < 100) return 0;
        lh = 0; ls++;
        if (ls == 60) begin
            ls = 0; lm++;
            if (lm == 60) begin
                lm = 0; lhr++;
                if (lhr == 24) begin
                    lhr = 0;
                    lwd = (lwd == 7) ? 1 : lwd + 1;
                    ldt++;
                    if (ldt > days_in(lmo, ly)) begin
                        ldt = 1; lmo++;
                        if (lmo == 13) begin lmo = 1; ly = (ly + 1) % 100; end
                    end
                end
            end
        end
        return 1;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 16; i++) vis[i] = 8'h00;
        vis[9] = 8'h80; vis[12] = 8'h01; vis[13] = 8'h01; vis[14] = 8'h01;
        lh = 0; ls = 0; lm = 0; lhr = 0; lwd = 1; ldt = 1; lmo = 1; ly = 0;
    endtask

    // one clock cycle: model the effect and drive the ports together
    task automatic step(input bit t, input bit we, input logic [3:0] a, input logic [7:0] d);
        logic [7:0] oc;
        bit ld, carry;
        oc = vis[8];
        ld = we && a == 4'd8 && oc[7] && !d[7];
        carry = 0;
        if (t && !vis[9][7] && !ld) carry = model_adv();
        if (carry && oc[7:6] == 2'b00)
            for (int i = 0; i < 16; i++)
                vis[i] = (vis[i] & ~mask_of(i)) | (live_byte(i) & mask_of(i));
        if (we) vis[a] = d;
        if (ld) begin
            lh = from_bcd(vis[1]); ls = from_bcd({1'b0, vis[9][6:0]});
            lm = from_bcd({1'b0, vis[10][6:0]}); lhr = from_bcd({2'b0, vis[11][5:0]});
            lwd = int'(vis[12][2:0]); ldt = from_bcd({2'b0, vis[13][5:0]});
            lmo = from_bcd({3'b0, vis[14][4:0]}); ly = from_bcd(vis[15]);
        end
        tick = t; wr_en = we; addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        tick = 0; wr_en = 0;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) step(1, 0, 4'd0, 8'h00);
    endtask

    task automatic check_val(input logic [3:0] a, input logic [7:0] exp, input string req);
        addr = a; #1;
        checks++;
        if (rd_data !== exp) begin
            failures++;
            $display("FAIL %s offset %0d actual=%02h expected=%02h", req, a, rd_data, exp);
        end
    endtask

    task automatic check_all(input string req);
        for (int i = 0; i < 16; i++) check_val(4'(i), vis[i], req);
    endtask

    task automatic set_time(input int yr, input int mo, input int dt, input int wd,
                            input int hr, input int mi, input int se, input int hu);
        step(0, 1, 4'd8, 8'h80);
        step(0, 1, 4'd15, to_bcd(yr));
        step(0, 1, 4'd14, to_bcd(mo));
        step(0, 1, 4'd13, to_bcd(dt));
        step(0, 1, 4'd12, to_bcd(wd));
        step(0, 1, 4'd11, to_bcd(hr));
        step(0, 1, 4'd10, to_bcd(mi));
        step(0, 1, 4'd9, to_bcd(se));
        step(0, 1, 4'd1, to_bcd(hu));
        step(0, 1, 4'd8, 8'h00);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4821));
        model_reset();
        @(negedge clk); @(negedge clk);
        rst = 0;

        // R10 reset values
        check_val(4'd9, 8'h80, "R10");
        check_val(4'd12, 8'h01, "R10");
        check_val(4'd13, 8'h01, "R10");
        check_val(4'd8, 8'h00, "R10");
        check_val(4'd15, 8'h00, "R10");

        // R4 stopped clock ignores ticks
        ticks(150);
        check_val(4'd9, 8'h80, "R4");
        check_val(4'd1, 8'h00, "R4");

        // R9 storage bytes
        step(0, 1, 4'd3, 8'hA5);
        step(0, 1, 4'd0, 8'h3C);
        check_val(4'd3, 8'hA5, "R9");
        check_val(4'd0, 8'h3C, "R9");

        // R4 start, R3 refresh once per second
        step(0, 1, 4'd9, 8'h00);
        ticks(99);
        check_val(4'd9, 8'h00, "R3");
        check_val(4'd1, 8'h00, "R3");
        ticks(1);
        check_val(4'd9, 8'h01, "R3");
        check_val(4'd1, 8'h00, "R3");
        ticks(40);
        check_val(4'd1, 8'h00, "R3");

        // R5 read freeze: live runs on, visible held
        step(0, 1, 4'd8, 8'h40);
        ticks(200);
        check_val(4'd9, 8'h01, "R5");
        step(0, 1, 4'd8, 8'h00);
        ticks(100);
        check_val(4'd9, 8'h04, "R5");
        check_all("R5");

        // R6 freeze written in the refresh cycle: refresh lands
        while (lh != 99) ticks(1);
        step(1, 1, 4'd8, 8'h40);
        check_val(4'd9, 8'h05, "R6");
        check_val(4'd8, 8'h40, "R6");
        ticks(100);
        check_val(4'd9, 8'h05, "R6");
        step(0, 1, 4'd8, 8'h00);

        // R7 load, R2 carries, R8 leap February
        set_time(24, 2, 28, 7, 23, 59, 59, 98);
        check_val(4'd13, 8'h28, "R7");
        ticks(2);
        check_val(4'd13, 8'h29, "R8");
        check_val(4'd14, 8'h02, "R8");
        check_val(4'd12, 8'h01, "R2");
        check_val(4'd11, 8'h00, "R2");
        set_time(23, 2, 28, 3, 23, 59, 59, 99);
        ticks(1);
        check_val(4'd13, 8'h01, "R8");
        check_val(4'd14, 8'h03, "R8");
        set_time(0, 2, 28, 3, 23, 59, 59, 99);
        ticks(1);
        check_val(4'd13, 8'h29, "R8");
        set_time(99, 12, 31, 5, 23, 59, 59, 99);
        ticks(1);
        check_val(4'd15, 8'h00, "R2");
        check_val(4'd14, 8'h01, "R2");
        check_val(4'd13, 8'h01, "R2");
        set_time(10, 4, 30, 5, 23, 59, 59, 99);
        ticks(1);
        check_val(4'd14, 8'h05, "R8");
        check_val(4'd13, 8'h01, "R8");

        // R7 tick in the load cycle is discarded
        set_time(5, 6, 10, 2, 12, 30, 0, 0);
        step(0, 1, 4'd8, 8'h80);
        step(0, 1, 4'd1, 8'h99);
        step(1, 1, 4'd8, 8'h00);
        ticks(1);
        check_val(4'd9, 8'h01, "R7");
        check_val(4'd1, 8'h00, "R7");

        // R9 unused bits survive a refresh
        step(0, 1, 4'd11, 8'hC0 | vis[11]);
        ticks(100);
        check_val(4'd11, vis[11], "R9");
        checks++;
        if (vis[11][7:6] != 2'b11) begin
            failures++;
            $display("FAIL R9 model lost unused bits actual=%02h expected=c?", vis[11]);
        end

        // R1 layout and mixed random operation
        for (int it = 0; it < 40; it++) begin
            int op;
            op = $urandom % 4;
            if (op == 0) begin
                int mo, yr;
                yr = $urandom % 100; mo = 1 + $urandom % 12;
                set_time(yr, mo, 1 + $urandom % days_in(mo, yr), 1 + $urandom % 7,
                         $urandom % 24, $urandom % 60, $urandom % 60, $urandom % 100);
            end else if (op == 1) begin
                step(0, 1, 4'd8, ($urandom % 2) ? 8'h40 : 8'h00);
            end else begin
                ticks(1 + $urandom % 250);
            end
            check_all("R1");
        end
        step(0, 1, 4'd8, 8'h00);
        ticks(150);
        check_all("R1");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule